// File: doc/BRIEF.md
# Banked Fault Status Register Access Controller

This block holds two copies of a fault status word: one for the secure world and one for the non-secure world. It accepts coprocessor-style read and write requests. Each request carries the privilege level of its requester, from 0 to 3. For each request the block does one of three things:

- completes the access on one bank;
- reports the instruction as undefined;
- raises a trap to level 2 with a fixed syndrome class.

The decision uses the following inputs:

- the requester level;
- the top-level secure-state selector;
- a flag that says level 2 is enabled;
- the width mode of level 2;
- three level-2 trap controls: a per-register trap, a read trap and a write trap.

At level 1, when level 2 is enabled, the controls are tested in a fixed order. The per-register trap is tested first. After it comes the trap for the access direction: the read trap for a read, the write trap for a write.

Requests at levels 1 and 2 always reach the non-secure copy. This copy also stands in for the single shared register of systems without a 32-bit level 3. Requests at level 3 choose the copy with the secure-state selector.

Each request gives a one-cycle response pulse in the cycle after it is presented. A permitted write updates the chosen copy at that same clock edge.

Top module: `fsr_bank_ctl`

## Requirements
- R1: A request at level 0 produces `undef_o` for one cycle, with `done_o` and `trap_o` low. It changes neither bank, and `rdata_o` stays zero.
- R2: The per-register trap is `ctl_reg_trap`. A level-1 request with `cfg_l2_en`=1 and `ctl_reg_trap`=1 traps for both reads and writes. The trap sets `trap_o`=1, `trap_lvl_o`=2 and `trap_cls_o`=0x03.
- R3: A level-1 read with `cfg_l2_en`=1 and `ctl_rd_trap`=1 traps, whatever the value of `ctl_wr_trap`.
- R4: A level-1 write with `cfg_l2_en`=1 and `ctl_wr_trap`=1 traps, whatever the value of `ctl_rd_trap`.
- R5: The trap controls have no effect when `cfg_l2_en`=0, or when the request is at level 2 or 3. Such a request completes.
- R6: Completed requests at levels 1 and 2 access the non-secure bank.
- R7: At level 3, `cfg_scr_ns`=0 selects the secure bank and `cfg_scr_ns`=1 selects the non-secure bank.
- R8: During a trap pulse, `trap_w32_o` equals `cfg_l2_w32` as sampled with the request: 1 marks a 32-bit level 2, 0 a 64-bit level 2. The signal is 0 when no trap is raised.
- R9: After reset both banks hold zero and all outputs are zero.
- R10: Each response is a single-cycle pulse in the cycle after the request, and at most one of `done_o`, `undef_o` and `trap_o` is high. A permitted write is visible to the next request. A read returns the value the bank held before its edge.
- R11: A trapped or undefined access leaves both banks unchanged. `rdata_o` is zero in every cycle without a completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lvl | input | 2 | Privilege level of the requester (0..3) |
| req_wdata | input | 32 | Write data |
| cfg_scr_ns | input | 1 | Secure-state selector, used at level 3 |
| cfg_l2_en | input | 1 | Level 2 enabled |
| cfg_l2_w32 | input | 1 | Level 2 runs in 32-bit mode |
| ctl_reg_trap | input | 1 | Per-register trap to level 2 |
| ctl_rd_trap | input | 1 | Read trap to level 2 |
| ctl_wr_trap | input | 1 | Write trap to level 2 |
| done_o | output | 1 | Access completed |
| rdata_o | output | 32 | Read data of a completed read, zero otherwise |
| undef_o | output | 1 | Undefined-instruction indication |
| trap_o | output | 1 | Trap raised |
| trap_lvl_o | output | 2 | Trap target level (2 while trapping) |
| trap_cls_o | output | 6 | Syndrome class (0x03 while trapping) |
| trap_w32_o | output | 1 | Trap variant: 32-bit level 2 |

## Verification
Directed sequences come first.

- Each bank is written at level 3 with distinct patterns and then read back under both selector values. This separates the secure copy from the non-secure copy.
- Level-1 requests are tried under every combination of the three trap controls, with level 2 enabled and disabled. This tells the per-register trap apart from the direction-specific traps, and shows that each direction ignores the other direction's control.
- Writes at level 0 and trapped writes are each followed by reads at level 3. These reads show that neither bank moved.

A long random phase follows. It mixes levels, directions and controls against a behavioural reference model. This exposes ordering faults, such as a read issued directly after a write.

// File: rtl/fsr_bank_pkg.sv
package fsr_bank_pkg;
   typedef enum logic [1:0] {
      OUT_NONE  = 2'd0,
      OUT_DONE  = 2'd1,
      OUT_UNDEF = 2'd2,
      OUT_TRAP  = 2'd3
   } fsr_outcome_e;

   typedef enum logic {
      BANK_NS = 1'b0,
      BANK_S  = 1'b1
   } fsr_bank_e;

   localparam int unsigned FSR_NBANK      = 2;
   localparam logic [1:0]  FSR_TRAP_LEVEL = 2'd2;
endpackage

// File: rtl/fsr_access_policy.sv
module fsr_access_policy
   import fsr_bank_pkg::*;
(
   input  logic         req_valid,
   input  logic         req_write,
   input  logic [1:0]   req_lvl,
   input  logic         cfg_scr_ns,
   input  logic         cfg_l2_en,
   input  logic         ctl_reg_trap,
   input  logic         ctl_rd_trap,
   input  logic         ctl_wr_trap,
   output fsr_outcome_e outcome,
   output fsr_bank_e    bank_sel
);
   logic dir_trap;
   logic l1_trap;

   // Direction-specific control: a read only looks at the read trap,
   // a write only at the write trap.
   assign dir_trap = req_write ? ctl_wr_trap : ctl_rd_trap;
   // Per-register trap ranks first; both lead to the same trap class.
   assign l1_trap  = cfg_l2_en & (ctl_reg_trap | dir_trap);

   always_comb begin
      outcome  = OUT_NONE;
      bank_sel = BANK_NS;
      if (req_valid) begin
         unique case (req_lvl)
            2'd0: outcome = OUT_UNDEF;
            2'd1: outcome = l1_trap ? OUT_TRAP : OUT_DONE;
            2'd2: outcome = OUT_DONE;
            default: begin
               outcome  = OUT_DONE;
               bank_sel = cfg_scr_ns ? BANK_NS : BANK_S;
            end
         endcase
      end
   end
endmodule

// File: rtl/fsr_bank_store.sv
module fsr_bank_store
   import fsr_bank_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  fsr_bank_e         sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] bank_q [FSR_NBANK];

   for (genvar b = 0; b < FSR_NBANK; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank_q[b] <= '0;
         else if (wr_en && (int'(sel) == b))
            bank_q[b] <= wdata;
      end
   end

   assign rdata = bank_q[sel];
endmodule

// File: rtl/fsr_bank_ctl.sv
module fsr_bank_ctl
   import fsr_bank_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CLASS_W    = 6,
   parameter int unsigned TRAP_CLASS = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [1:0]         req_lvl,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic               cfg_scr_ns,
   input  logic               cfg_l2_en,
   input  logic               cfg_l2_w32,
   input  logic               ctl_reg_trap,
   input  logic               ctl_rd_trap,
   input  logic               ctl_wr_trap,
   output logic               done_o,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               undef_o,
   output logic               trap_o,
   output logic [1:0]         trap_lvl_o,
   output logic [CLASS_W-1:0] trap_cls_o,
   output logic               trap_w32_o
);
   localparam logic [CLASS_W-1:0] CLS_VAL = CLASS_W'(TRAP_CLASS);

   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (TRAP_CLASS >= (1 << CLASS_W)) begin : g_bad_class
      $error("TRAP_CLASS does not fit in CLASS_W bits");
   end

   fsr_outcome_e      outcome;
   fsr_bank_e         bank_sel;
   logic [DATA_W-1:0] bank_rd;
   logic              wr_en;

   fsr_access_policy u_policy (
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_lvl      (req_lvl),
      .cfg_scr_ns   (cfg_scr_ns),
      .cfg_l2_en    (cfg_l2_en),
      .ctl_reg_trap (ctl_reg_trap),
      .ctl_rd_trap  (ctl_rd_trap),
      .ctl_wr_trap  (ctl_wr_trap),
      .outcome      (outcome),
      .bank_sel     (bank_sel)
   );

   assign wr_en = (outcome == OUT_DONE) && req_write;

   fsr_bank_store #(.DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .sel   (bank_sel),
      .wdata (req_wdata),
      .rdata (bank_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o     <= 1'b0;
         undef_o    <= 1'b0;
         trap_o     <= 1'b0;
         trap_w32_o <= 1'b0;
         rdata_o    <= '0;
      end else begin
         done_o     <= (outcome == OUT_DONE);
         undef_o    <= (outcome == OUT_UNDEF);
         trap_o     <= (outcome == OUT_TRAP);
         trap_w32_o <= (outcome == OUT_TRAP) && cfg_l2_w32;
         rdata_o    <= ((outcome == OUT_DONE) && !req_write) ? bank_rd : '0;
      end
   end

   assign trap_lvl_o = trap_o ? FSR_TRAP_LEVEL : 2'd0;
   assign trap_cls_o = trap_o ? CLS_VAL : '0;

   // R1
   el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_lvl == 2'd0) |=> (undef_o && !done_o && !trap_o));

   // R2
   reg_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_lvl == 2'd1 && cfg_l2_en && ctl_reg_trap)
      |=> (trap_o && trap_lvl_o == 2'd2 && trap_cls_o == CLS_VAL));

   // R5
   upper_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_lvl[1]) |=> (done_o && !trap_o && !undef_o));

   // R10
   pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, undef_o, trap_o}));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!done_o && !undef_o && !trap_o));

   // R11
   rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (rdata_o == '0));
endmodule

// File: tb/tb_fsr_bank_ctl.sv
module tb_fsr_bank_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0;
   logic [1:0]  req_lvl = 0;
   logic [31:0] req_wdata = 0;
   logic        cfg_scr_ns = 0, cfg_l2_en = 0, cfg_l2_w32 = 0;
   logic        ctl_reg_trap = 0, ctl_rd_trap = 0, ctl_wr_trap = 0;
   logic        done_o, undef_o, trap_o, trap_w32_o;
   logic [31:0] rdata_o;
   logic [1:0]  trap_lvl_o;
   logic [5:0]  trap_cls_o;

   int n_cmp = 0, n_bad = 0;

   // reference model state
   logic [31:0] m_sec = 0, m_ns = 0;
   logic        e_done = 0, e_undef = 0, e_trap = 0, e_w32 = 0;
   logic [31:0] e_rdata = 0;
   string       e_tag = "R9";

   always #2 clk = ~clk;   // 250 MHz

   fsr_bank_ctl dut (.*);

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk({done_o, undef_o, trap_o} == {e_done, e_undef, e_trap}, e_tag, "done/undef/trap",
          {29'd0, done_o, undef_o, trap_o}, {29'd0, e_done, e_undef, e_trap});
      chk(rdata_o === e_rdata, e_done ? e_tag : "R11", "rdata", rdata_o, e_rdata);
      chk(trap_w32_o === e_w32, "R8", "trap_w32", {31'd0, trap_w32_o}, {31'd0, e_w32});
      chk(trap_lvl_o === (e_trap ? 2'd2 : 2'd0) && trap_cls_o === (e_trap ? 6'h03 : 6'h00),
          e_tag, "trap lvl/cls", {24'd0, trap_lvl_o, trap_cls_o},
          {24'd0, (e_trap ? 2'd2 : 2'd0), (e_trap ? 6'h03 : 6'h00)});
   endtask

   // Compute the expected response for the request now being driven, and update the model.
   task automatic model_step();
      bit trap_hit, dir;
      e_done = 0; e_undef = 0; e_trap = 0; e_w32 = 0; e_rdata = 0; e_tag = "R10";
      if (!req_valid) return;
      if (req_lvl == 0) begin
         e_undef = 1; e_tag = "R1"; return;
      end
      if (req_lvl == 1 && cfg_l2_en) begin
         dir = req_write ? ctl_wr_trap : ctl_rd_trap;
         trap_hit = ctl_reg_trap || dir;
         if (trap_hit) begin
            e_trap = 1; e_w32 = cfg_l2_w32;
            e_tag = ctl_reg_trap ? "R2" : (req_write ? "R4" : "R3");
            return;
         end
      end
      e_done = 1;
      if (req_lvl == 3) begin
         e_tag = "R7";
         if (cfg_scr_ns) begin
            if (req_write) m_ns = req_wdata; else e_rdata = m_ns;
         end else begin
            if (req_write) m_sec = req_wdata; else e_rdata = m_sec;
         end
      end else begin
         e_tag = (ctl_reg_trap || ctl_rd_trap || ctl_wr_trap) ? "R5" : "R6";
         if (req_write) m_ns = req_wdata; else e_rdata = m_ns;
      end
   endtask

   // One request per cycle: compare the previous response, then drive the next request.
   task automatic issue(input bit v, input bit w, input logic [1:0] lvl, input logic [31:0] d,
                        input bit ns, input bit l2en, input bit w32,
                        input bit t5, input bit tr, input bit tw);
      @(negedge clk);
      compare();
      req_valid = v; req_write = w; req_lvl = lvl; req_wdata = d;
      cfg_scr_ns = ns; cfg_l2_en = l2en; cfg_l2_w32 = w32;
      ctl_reg_trap = t5; ctl_rd_trap = tr; ctl_wr_trap = tw;
      model_step();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      compare();                         // R9 reset state
      rst_n = 1'b1;
      // R9: both banks read zero after reset
      issue(1,0,3,0, 0,0,0, 0,0,0);
      issue(1,0,3,0, 1,0,0, 0,0,0);
      // R7: separate banks at level 3
      issue(1,1,3,32'hA5A5_0001, 0,0,0, 0,0,0);
      issue(1,1,3,32'h5A5A_0002, 1,0,0, 0,0,0);
      issue(1,0,3,0, 0,0,0, 0,0,0);
      issue(1,0,3,0, 1,0,0, 0,0,0);
      // R6: levels 1 and 2 hit the non-secure bank
      issue(1,1,1,32'h1111_0001, 0,0,0, 0,0,0);
      issue(1,0,2,0, 0,0,0, 0,0,0);
      issue(1,1,2,32'h2222_0002, 0,1,0, 0,0,0);
      issue(1,0,3,0, 0,0,0, 0,0,0);
      issue(1,0,1,0, 0,0,0, 0,0,0);
      // R1/R11: level-0 write changes nothing
      issue(1,1,0,32'hDEAD_BEEF, 0,0,0, 0,0,0);
      issue(1,0,0,0, 1,0,0, 0,0,0);
      issue(1,0,3,0, 1,0,0, 0,0,0);
      issue(1,0,3,0, 0,0,0, 0,0,0);
      // R2/R3/R4/R8: all control combinations at level 1, both directions, l2 on and off
      for (int c = 0; c < 64; c++) begin
         issue(1, c[0], 1, 32'hC0DE_0000 | c, c[5], c[1], c[2], c[3], c[4], c[5]);
         issue(1, 0, 3, 0, 1, 0, 0, 0, 0, 0);
      end
      // R5: controls set at levels 2 and 3
      issue(1,1,2,32'h7777_0007, 0,1,1, 1,1,1);
      issue(1,0,3,0, 1,1,0, 1,1,1);
      // R10: idle gaps and back-to-back write/read
      issue(0,0,0,0, 0,0,0, 0,0,0);
      issue(1,1,3,32'h0BAD_F00D, 0,0,0, 0,0,0);
      issue(1,0,3,0, 0,0,0, 0,0,0);
      issue(0,1,3,32'hFFFF_FFFF, 0,0,0, 0,0,0);
      issue(1,0,3,0, 0,0,0, 0,0,0);
      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom;
         issue(r[0] | r[1], r[2], r[4:3], $urandom, r[5], r[6], r[7],
               r[8] & r[9], r[10], r[11]);
      end
      issue(0,0,0,0, 0,0,0, 0,0,0);
      @(negedge clk);
      compare();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule